// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block generates one pulse-width-modulated output from a period counter and a queue of duty samples. Software writes duty values into a four-deep sample queue through a small word-addressed register port. The counter advances on prescaled ticks of the system clock, and each period is `period + 2` ticks long. The output is high from the start of a period until the count reaches the active sample, and low for the rest of it.

A queued sample becomes active only at a period boundary, and only after the current sample has served its programmed number of periods. If the queue is empty at that boundary, the current sample is kept. A smaller duty written in the middle of a period therefore never stretches that period to full-high.

The register port has no read strobe. `rdata` follows `addr` combinationally. Writes take effect on the clock edge where `wr_en` is high. A clock-enable input stands in for clock-source selection. A self-clearing soft-reset bit returns every register to its reset value.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x10 (empty flag set, fill 0), the counter reads 0 and `pwm_out` is low.
- R2: Each write to the duty address (0x08) appends a sample to a 4-entry queue. Status bits 2:0 give the fill count, 0 to 4, and status bit 4 is set exactly when the fill count is 0.
- R3: A duty write while the queue holds 4 entries is dropped and sets status bit 7. Writing 1 to status bits 7, 6 or 5 clears that bit, and writing 0 leaves it unchanged.
- R4: One period lasts `period + 2` prescaled ticks. Control bits 19:8 hold the divide ratio minus one. The counter holds its value while `clk_en` is low or while the clock-select field (control bits 7:6) is 0.
- R5: In normal mode the output is high while count < active sample. An active sample of 0 gives a constant low output, and a sample of `period + 2` or more gives a constant high output.
- R6: Control bits 3:2 (codes 0, 1, 2, 3) set 1, 2, 4 or 8 uses of each sample. At start, and at the rollover that ends the last use, the queue head becomes active. If the queue is empty at that point, the previous sample is reused.
- R7: A duty write made mid-period to an empty queue does not change the current period's pulse. It takes effect from the next qualifying rollover.
- R8: Output mode, control bits 5:4: 0 is normal, 1 is inverted, 2 and 3 hold the output low.
- R9: While the enable bit (control bit 0) is 0, `pwm_out` is 0 whatever the mode, and the duty address reads 0. While enabled, the duty address reads the active sample.
- R10: Writing 1 to control bit 1 resets all registers, the queue and the counter. The bit reads back as 0 afterwards.
- R11: The period register (0x0C) stores a written 0xFFFF as 0xFFFE, and it reads back as 0xFFFE.
- R12: Status bit 5 is set at every period rollover. Status bit 6 is set when the counter steps onto the active sample value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Tick enable for the prescaler (reduced clock source) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte address: 0x00 control, 0x04 status, 0x08 duty, 0x0C period, 0x10 counter |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from `addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions check on every cycle that:
- the output is low while the block is disabled or in a held-low mode;
- the queue never reports more than four entries;
- an overflowing duty write raises the error flag;
- the active sample changes only on a start or end-of-use rollover;
- the counter returns to zero after a rollover;
- soft reset clears itself;
- the period register clamps.

The bench's scenarios are needed for what the assertions cannot see cycle by cycle:
- the measured pulse widths across repeat counts and prescale ratios;
- the order in which queued samples appear;
- the deferred mid-period write;
- the constant-low and constant-high extremes;
- inversion against the live counter.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_STAT = 5'h04;
  localparam logic [4:0] A_DUTY = 5'h08;
  localparam logic [4:0] A_PER  = 5'h0C;
  localparam logic [4:0] A_CNT  = 5'h10;

  typedef enum logic [1:0] {
    OUT_NORM = 2'd0,
    OUT_INV  = 2'd1,
    OUT_LOW  = 2'd2,
    OUT_LOWX = 2'd3
  } out_mode_e;

  // number of periods each sample is used for
  function automatic logic [3:0] uses_of(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // output level before the enable gate
  function automatic logic level_of(input logic [1:0] mode, input logic below);
    case (mode)
      OUT_NORM: return below;
      OUT_INV:  return !below;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH+1);

  logic [PW-1:0] wr_q, rd_q;
  logic [FW-1:0] fill_q;
  logic [DW-1:0] slot_w [DEPTH];
  logic          do_push, do_pop;

  assign do_push = push && (fill_q != FW'(DEPTH));
  assign do_pop  = pop && (fill_q != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            slot_q <= '0;
      else if (do_push && wr_q == PW'(i))    slot_q <= din;
    end
    assign slot_w[i] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0; rd_q <= '0; fill_q <= '0;
    end else if (clr) begin
      wr_q <= '0; rd_q <= '0; fill_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      if (do_push && !do_pop)      fill_q <= fill_q + 1'b1;
      else if (do_pop && !do_push) fill_q <= fill_q - 1'b1;
    end
  end

  assign dout = slot_w[rd_q];
  assign fill = fill_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int DW  = 16,
  parameter int PSW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           run,
  input  logic           tick,
  input  logic [PSW-1:0] prescale,
  input  logic [DW-1:0]  last,
  output logic [DW-1:0]  cnt,
  output logic           ptick,
  output logic           roll
);
  logic [PSW-1:0] pre_q;
  logic [DW-1:0]  cnt_q;

  assign ptick = run && tick && (pre_q >= prescale);
  assign roll  = ptick && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0; cnt_q <= '0;
    end else if (clr || !run) begin
      pre_q <= '0; cnt_q <= '0;
    end else if (tick) begin
      pre_q <= (pre_q >= prescale) ? '0 : pre_q + 1'b1;
      if (ptick) cnt_q <= roll ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen #(
  parameter int DW    = 16,
  parameter int PSW   = 12,
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_en,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        pwm_out
);
  import pwm_fifo_pkg::*;

  localparam int FW = $clog2(DEPTH+1);
  localparam logic [DW-1:0] PER_MAX = {{(DW-1){1'b1}}, 1'b0};

  function automatic logic [DW-1:0] clamp_per(input logic [DW-1:0] v);
    return (v > PER_MAX) ? PER_MAX : v;
  endfunction

  // control state
  logic           en_q, srst_q;
  logic [1:0]     rep_q, mode_q, csel_q;
  logic [PSW-1:0] pre_q;
  logic [DW-1:0]  per_q, active_q;
  logic [2:0]     rep_cnt_q;
  logic           running_q;
  logic           roll_st, cmp_st, werr_st;

  // named events
  logic           clr, ctrl_wr, stat_wr, duty_wr, per_wr;
  logic           ptick, roll, last_use, load_evt, pop, cmp_evt, ovf_evt, below;
  logic [DW-1:0]  cnt, fifo_head;
  logic [FW-1:0]  fill;

  assign clr     = srst_q;
  assign ctrl_wr = wr_en && !clr && (addr == A_CTRL);
  assign stat_wr = wr_en && !clr && (addr == A_STAT);
  assign duty_wr = wr_en && !clr && (addr == A_DUTY);
  assign per_wr  = wr_en && !clr && (addr == A_PER);

  assign last_use = (4'(rep_cnt_q) + 4'd1) >= uses_of(rep_q);
  assign load_evt = (en_q && !running_q) || (roll && last_use);
  assign pop      = load_evt && (fill != '0);
  assign ovf_evt  = duty_wr && (fill == FW'(DEPTH));
  assign cmp_evt  = ptick && !roll && ((DW+1)'(cnt) + 1'b1 == (DW+1)'(active_q));
  assign below    = cnt < active_q;

  pwm_sample_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(duty_wr), .din(wdata[DW-1:0]),
    .pop(pop), .dout(fifo_head), .fill(fill)
  );

  pwm_timebase #(.DW(DW), .PSW(PSW)) i_tb (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .run(en_q && running_q), .tick(clk_en && (csel_q != 2'd0)),
    .prescale(pre_q), .last(per_q + 1'b1),
    .cnt(cnt), .ptick(ptick), .roll(roll)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; srst_q <= 1'b0; rep_q <= '0; mode_q <= '0; csel_q <= '0; pre_q <= '0;
      per_q <= '0; active_q <= '0; rep_cnt_q <= '0; running_q <= 1'b0;
      roll_st <= 1'b0; cmp_st <= 1'b0; werr_st <= 1'b0;
    end else if (clr) begin
      en_q <= 1'b0; srst_q <= 1'b0; rep_q <= '0; mode_q <= '0; csel_q <= '0; pre_q <= '0;
      per_q <= '0; active_q <= '0; rep_cnt_q <= '0; running_q <= 1'b0;
      roll_st <= 1'b0; cmp_st <= 1'b0; werr_st <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= wdata[0];
        srst_q <= wdata[1];
        rep_q  <= wdata[3:2];
        mode_q <= wdata[5:4];
        csel_q <= wdata[7:6];
        pre_q  <= wdata[8 +: PSW];
      end
      if (per_wr) per_q <= clamp_per(wdata[DW-1:0]);
      running_q <= en_q;
      if (pop) active_q <= fifo_head;
      if (load_evt)  rep_cnt_q <= '0;
      else if (roll) rep_cnt_q <= rep_cnt_q + 1'b1;
      roll_st <= roll    || (roll_st && !(stat_wr && wdata[5]));
      cmp_st  <= cmp_evt || (cmp_st  && !(stat_wr && wdata[6]));
      werr_st <= ovf_evt || (werr_st && !(stat_wr && wdata[7]));
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = 32'({pre_q, csel_q, mode_q, rep_q, srst_q, en_q});
      A_STAT: rdata = {24'd0, werr_st, cmp_st, roll_st, (fill == '0), 1'b0, 3'(fill)};
      A_DUTY: rdata = en_q ? 32'(active_q) : 32'd0;
      A_PER:  rdata = 32'(per_q);
      A_CNT:  rdata = 32'(cnt);
      default: rdata = '0;
    endcase
  end

  assign pwm_out = en_q && running_q && level_of(mode_q, below);
endmodule

// File: rtl/pwm_fifo_chk.sv
module pwm_fifo_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       en,
  input logic [1:0]                 mode,
  input logic                       pwm_out,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic                       duty_wr,
  input logic                       werr,
  input logic [DW-1:0]              active,
  input logic                       clr,
  input logic                       load_evt,
  input logic                       srst,
  input logic                       roll,
  input logic [DW-1:0]              cnt,
  input logic                       per_wr,
  input logic [DW-1:0]              wlo,
  input logic [DW-1:0]              per
);
  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));

  // R3
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_wr && !clr && fill == ($clog2(DEPTH+1))'(DEPTH)) |=> werr);

  // R9
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  // R8
  mode_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1]) |-> !pwm_out);

  // R7
  commit_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(active) && !$past(clr)) |-> $past(load_evt));

  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !srst);

  // R4
  roll_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (cnt == '0));

  // R11
  per_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr && wlo == '1) |=> (per == {{(DW-1){1'b1}}, 1'b0}));
endmodule

bind pwm_fifo_gen pwm_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .pwm_out(pwm_out),
  .fill(fill), .duty_wr(duty_wr), .werr(werr_st), .active(active_q),
  .clr(clr), .load_evt(load_evt), .srst(srst_q), .roll(roll), .cnt(cnt),
  .per_wr(per_wr), .wlo(wdata[DW-1:0]), .per(per_q)
);

// File: tb/test_pwm_fifo_gen.sv
module test_pwm_fifo_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;

  int n_run = 0, n_fail = 0, cyc = 0;
  int exp_q[$];
  string tag_q[$];
  int hi_run = 0;

  always #2 clk = ~clk;

  pwm_fifo_gen i_pwm_fifo_gen (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [31:0] ctl(input int en, input int rep, input int mode, input int pre);
    return 32'(en) | 32'(rep << 2) | 32'(mode << 4) | 32'(1 << 6) | 32'(pre << 8);
  endfunction

  // driver side of the scoreboard: expected pulse widths
  task automatic expect_pulse(input string tag, input int w);
    exp_q.push_back(w); tag_q.push_back(tag);
  endtask

  // monitor: measures high runs and pops expectations
  always @(negedge clk) begin
    cyc++;
    if (pwm_out) hi_run++;
    else begin
      if (hi_run > 0 && exp_q.size() > 0) check(tag_q.pop_front(), hi_run, exp_q.pop_front());
      hi_run = 0;
    end
  end

  // watchdog
  initial begin
    wait (cyc > 150000);
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, c1, c2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h00, d); check("R1 ctrl", d, 0);
    rd(5'h04, d); check("R1 stat", d, 32'h10);
    rd(5'h10, d); check("R1 count", d, 0);
    check("R1 out", pwm_out, 0);

    // R9 disabled output low even when inverted
    wr(5'h00, 32'h10);
    repeat (4) @(negedge clk);
    check("R9 off inverted", pwm_out, 0);

    // R2/R3 queue fill and overflow
    for (int i = 1; i <= 5; i++) wr(5'h08, 32'(i));
    rd(5'h04, d); check("R2 fill", d[2:0], 4); check("R2 empty", d[4], 0);
    check("R3 werr", d[7], 1);
    wr(5'h04, 32'h00); rd(5'h04, d); check("R3 zero write keeps", d[7], 1);
    wr(5'h04, 32'h80); rd(5'h04, d); check("R3 w1c", d[7], 0);

    // R10 soft reset
    wr(5'h00, 32'h2);
    repeat (2) @(negedge clk);
    rd(5'h00, d); check("R10 ctrl", d, 0);
    rd(5'h04, d); check("R10 stat", d, 32'h10);

    // R6 repeat 2 uses, queue order, reuse when empty
    wr(5'h0C, 32'd8);
    wr(5'h08, 32'd3); wr(5'h08, 32'd5); wr(5'h08, 32'd7);
    rd(5'h04, d); check("R2 fill3", d[2:0], 3);
    expect_pulse("R6", 3); expect_pulse("R6", 3);
    expect_pulse("R6", 5); expect_pulse("R6", 5);
    expect_pulse("R6", 7); expect_pulse("R6", 7); expect_pulse("R6 reuse", 7);
    wr(5'h00, ctl(1, 1, 0, 0));
    wait (exp_q.size() == 0);
    rd(5'h08, d); check("R9 duty enabled", d, 7);
    rd(5'h04, d); check("R12 roll", d[5], 1); check("R12 cmp", d[6], 1);

    // R7 mid-period smaller sample is deferred
    wr(5'h00, ctl(1, 0, 0, 0));
    @(posedge pwm_out); @(negedge clk); @(negedge clk);
    expect_pulse("R7 current", 7); expect_pulse("R7 next", 2); expect_pulse("R7 next", 2);
    wr(5'h08, 32'd2);
    wait (exp_q.size() == 0);

    // R5 extremes
    wr(5'h08, 32'd0);
    repeat (30) @(negedge clk);
    d = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); d = d | 32'(pwm_out); end
    check("R5 const low", d, 0);
    wr(5'h08, 32'd20);
    repeat (30) @(negedge clk);
    d = 1;
    for (int i = 0; i < 12; i++) begin @(negedge clk); d = d & 32'(pwm_out); end
    check("R5 const high", d, 1);

    // R8 inverted against live count
    wr(5'h08, 32'd4);
    repeat (30) @(negedge clk);
    wr(5'h00, ctl(1, 0, 1, 0));
    for (int i = 0; i < 6; i++) begin
      repeat (i % 3) @(negedge clk);
      rd(5'h10, c1);
      check("R8 inverted", pwm_out, !(c1 < 4));
    end
    wr(5'h00, ctl(1, 0, 2, 0));
    d = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); d = d | 32'(pwm_out); end
    check("R8 held low", d, 0);

    // R9 disable
    wr(5'h00, ctl(0, 0, 1, 0));
    repeat (3) @(negedge clk);
    check("R9 off", pwm_out, 0);
    rd(5'h08, d); check("R9 duty off", d, 0);
    wr(5'h04, 32'hE0); rd(5'h04, d); check("R3 w1c all", d[7:5], 0);

    // R4 prescaler divide 3, period 0
    wr(5'h00, 32'h2);
    repeat (2) @(negedge clk);
    wr(5'h0C, 32'd0); wr(5'h08, 32'd1);
    expect_pulse("R4 prescale", 3); expect_pulse("R4 prescale", 3); expect_pulse("R4 prescale", 3);
    wr(5'h00, ctl(1, 0, 0, 2));
    wait (exp_q.size() == 0);
    wr(5'h00, 32'h2);
    repeat (2) @(negedge clk);
    wr(5'h0C, 32'd50); wr(5'h08, 32'd10);
    wr(5'h00, ctl(1, 0, 0, 0));
    repeat (5) @(negedge clk);
    clk_en = 1'b0;
    rd(5'h10, c1); repeat (5) @(negedge clk); rd(5'h10, c2);
    check("R4 freeze", c2, c1);
    clk_en = 1'b1;
    rd(5'h10, c1); repeat (3) @(negedge clk); rd(5'h10, c2);
    check("R4 advances", c2, c1 + 4);

    // R11 clamp
    wr(5'h0C, 32'hFFFF); rd(5'h0C, d); check("R11 clamp", d, 32'hFFFE);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule